// File: doc/BRIEF.md
# Reloading Down-Count Periodic Interrupt Timer

This block is a 32-bit timer that counts down at a programmable rate and raises an interrupt each time the count runs out. Software sets it up through a small word-addressed register port. It programs a reload value, a divide ratio and one of two tick sources, and it chooses between two reload behaviours. In the first, each period restarts from the programmed reload value, which gives a fixed-period interrupt. In the second, the counter wraps to all-ones, which makes a long free-running countdown after a single programmed period.

The two tick enables stand in for the selectable clock sources. The block runs entirely on its own clock and takes a single-cycle tick pulse from whichever source is selected. A divider then thins these source ticks by the programmed ratio. An immediate-load option copies a newly written reload value straight into the counter. A soft-reset command in the control word puts every register back into its power-up state.

Top module: `prdt_timer`

## Requirements
- R1: Word offsets are: 0 control, 1 status, 2 reload value, 3 compare, 4 counter. The counter is read only. Reads of offsets 5 to 7 return 0. Writes to offset 4 or to offsets 5 to 7 change nothing.
- R2: Control bit positions are: 0 enable, 1 enable-mode (stored only), 2 interrupt enable, 3 reload select, 15:4 divide field, 16 soft reset, 17 immediate load, 21:18 stored-only mode bits, 25:24 tick source. A write keeps bits 25:0 with bit 16 forced to 0, and bits 31:26 read 0.
- R3: A counting tick occurs once per (divide field + 1) selected source ticks. Source code 0 selects nothing, codes 1 and 2 select `tick_a_i`, and code 3 selects `tick_b_i`.
- R4: The counter holds its value while enable is 0 or the source code is 0.
- R5: A counting tick decrements a nonzero counter by one. A counting tick that finds the counter at zero is an expiry: the counter is reloaded instead of decremented, and status bit 0 is set.
- R6: On expiry the counter takes the reload value when reload select is 1, and 0xFFFFFFFF when it is 0.
- R7: `irq_o` is high exactly when status bit 0 and interrupt enable are both 1.
- R8: Any write to offset 1 clears status bit 0. If an expiry happens in the same cycle, the flag is set instead. Status reads return the flag in bit 0 and zeros elsewhere.
- R9: A write to offset 2 updates the reload value. When immediate load is 1, the counter also takes the written value at that edge, overriding any counting tick in that cycle.
- R10: Hard reset, and a control write with bit 16 set, clear control, the flag and compare to 0, and set the reload value and the counter to 0xFFFFFFFF.
- R11: A control write clears the divider's progress, and no counting tick occurs in the cycle of that write.
- R12: The compare register stores and returns any 32-bit value and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_i | input | 1 | Write strobe for one cycle |
| reg_addr_i | input | 3 | Word offset of the access |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| tick_a_i | input | 1 | Tick enable of the first source |
| tick_b_i | input | 1 | Tick enable of the second source |
| irq_o | output | 1 | Interrupt request, level |

## Verification
On every cycle, the assertions check the following:
- the counter never moves by more than one step without a write;
- it stays frozen when disabled or sourceless;
- the flag only rises from a zero count, and the value loaded at that point matches the reload select;
- a status write away from an expiry leaves the flag clear;
- the divider never passes its limit;
- the soft-reset bit never sticks.

Only the bench's scenarios can show the exact period produced by a given divide ratio and source pattern, the restart of the divider on a control write, and the priority of an immediate load over a tick. The same holds for the reset values and for the silence of unmapped offsets. The bench shows these by comparing every register readback and the interrupt against its own model on every cycle, while random writes and tick patterns run.

// File: rtl/prdt_pkg.sv
package prdt_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_LOAD = 2;
  localparam int OFS_CMP  = 3;
  localparam int OFS_CNT  = 4;

  localparam int B_EN     = 0;
  localparam int B_IE     = 2;
  localparam int B_RLD    = 3;
  localparam int B_DIV_LO = 4;
  localparam int B_SWR    = 16;
  localparam int B_IMM    = 17;
  localparam int B_SRC_LO = 24;
  localparam int SRC_W    = 2;

  localparam logic [31:0] CTRL_KEEP = 32'h03FE_FFFF;

  typedef enum logic [SRC_W-1:0] {
    SRC_OFF = 2'd0,
    SRC_A0  = 2'd1,
    SRC_A1  = 2'd2,
    SRC_B   = 2'd3
  } src_sel_e;
endpackage

// File: rtl/prdt_prescale.sv
module prdt_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             src_tick_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] pcnt_o
);
  logic [DIV_W-1:0] pcnt_q, pcnt_d;
  logic             pcnt_en, adv, wrap;

  always_comb begin
    adv     = run_i && src_tick_i && !restart_i;
    wrap    = adv && (pcnt_q == div_i);
    pcnt_en = adv || restart_i;
    pcnt_d  = (restart_i || wrap) ? '0 : pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  assign tick_o = wrap;
  assign pcnt_o = pcnt_q;
endmodule

// File: rtl/prdt_regs.sv
module prdt_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swr_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_load_i,
  input  logic              wr_cmp_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cmp_o
);
  import prdt_pkg::*;

  logic [DATA_W-1:0] ctrl_q, ctrl_d, load_q, load_d, cmp_q, cmp_d;
  logic              ctrl_en, load_en, cmp_en;

  always_comb begin
    ctrl_en = wr_ctrl_i;
    load_en = wr_load_i || swr_i;
    cmp_en  = wr_cmp_i  || swr_i;
    ctrl_d  = swr_i ? '0 : (wdata_i & DATA_W'(CTRL_KEEP));
    load_d  = swr_i ? '1 : wdata_i;
    cmp_d   = swr_i ? '0 : wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '1;
      cmp_q  <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (load_en) load_q <= load_d;
      if (cmp_en)  cmp_q  <= cmp_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/prdt_count.sv
module prdt_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              swr_i,
  input  logic              ld_now_i,
  input  logic [DATA_W-1:0] ld_val_i,
  input  logic              reload_sel_i,
  input  logic [DATA_W-1:0] reload_val_i,
  input  logic              sts_clr_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              flag_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              flag_q, flag_d;
  logic              cnt_en, flag_en, expire;

  always_comb begin
    expire  = tick_i && (cnt_q == '0);
    cnt_en  = swr_i || ld_now_i || tick_i;
    flag_en = swr_i || expire || sts_clr_i;
    if (swr_i)         cnt_d = '1;
    else if (ld_now_i) cnt_d = ld_val_i;
    else if (expire)   cnt_d = reload_sel_i ? reload_val_i : '1;
    else               cnt_d = cnt_q - 1'b1;
    if (swr_i)       flag_d = 1'b0;
    else if (expire) flag_d = 1'b1;
    else             flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '1;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/prdt_timer.sv
module prdt_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tick_a_i,
  input  logic              tick_b_i,
  output logic              irq_o
);
  import prdt_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              wr_ctrl, wr_stat, wr_load, wr_cmp, swr;
  logic [DATA_W-1:0] ctrl_q, load_q, cmp_q, cnt_q;
  logic              flag_q, run, src_tick, tick;
  logic [DIV_W-1:0]  psc_cnt;
  src_sel_e          src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    wr_ctrl = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CTRL));
    wr_stat = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_STAT));
    wr_load = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_LOAD));
    wr_cmp  = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_CMP));
    swr     = wr_ctrl && reg_wdata_i[B_SWR];
  end

  prdt_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_core_n), .swr_i(swr), .wr_ctrl_i(wr_ctrl),
    .wr_load_i(wr_load), .wr_cmp_i(wr_cmp), .wdata_i(reg_wdata_i),
    .ctrl_o(ctrl_q), .load_o(load_q), .cmp_o(cmp_q)
  );

  always_comb begin
    src = src_sel_e'(ctrl_q[B_SRC_LO +: SRC_W]);
    unique case (src)
      SRC_OFF:        src_tick = 1'b0;
      SRC_A0, SRC_A1: src_tick = tick_a_i;
      SRC_B:          src_tick = tick_b_i;
      default:        src_tick = 1'b0;
    endcase
    run = ctrl_q[B_EN] && (src != SRC_OFF);
  end

  prdt_prescale #(.DIV_W(DIV_W)) psc_i (
    .clk(clk), .rst_n(rst_core_n), .run_i(run), .src_tick_i(src_tick),
    .restart_i(wr_ctrl), .div_i(ctrl_q[B_DIV_LO +: DIV_W]),
    .tick_o(tick), .pcnt_o(psc_cnt)
  );

  prdt_count #(.DATA_W(DATA_W)) cnt_i (
    .clk(clk), .rst_n(rst_core_n), .tick_i(tick), .swr_i(swr),
    .ld_now_i(wr_load && ctrl_q[B_IMM]), .ld_val_i(reg_wdata_i),
    .reload_sel_i(ctrl_q[B_RLD]), .reload_val_i(load_q),
    .sts_clr_i(wr_stat), .cnt_o(cnt_q), .flag_o(flag_q)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_W'(OFS_CTRL): reg_rdata_o = ctrl_q;
      ADDR_W'(OFS_STAT): reg_rdata_o = DATA_W'(flag_q);
      ADDR_W'(OFS_LOAD): reg_rdata_o = load_q;
      ADDR_W'(OFS_CMP):  reg_rdata_o = cmp_q;
      ADDR_W'(OFS_CNT):  reg_rdata_o = cnt_q;
      default:           reg_rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q && ctrl_q[B_IE];
endmodule

// File: rtl/prdt_timer_chk.sv
module prdt_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int DIV_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] ctrl,
  input logic [DATA_W-1:0] load,
  input logic [DATA_W-1:0] cnt,
  input logic              flag,
  input logic [DIV_W-1:0]  pcnt,
  input logic              irq
);
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && (!ctrl[0] || ctrl[25:24] == 2'd0)) |=> $stable(cnt)); // R4
  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1)); // R5
  AST_FLAG_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cnt) == '0)); // R5
  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag) && !$past(wr)) |-> (cnt == (ctrl[3] ? load : '1))); // R6
  AST_IRQ_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && !$past(wr)) |-> ($past(cnt) == '0)); // R7
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(1) && cnt != '0) |=> !flag); // R8
  AST_SWR_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[16]); // R2
  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= ctrl[4 +: DIV_W]); // R3
endmodule

bind prdt_timer prdt_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_core_n), .wr(reg_wr_i), .addr(reg_addr_i),
  .ctrl(ctrl_q), .load(load_q), .cnt(cnt_q), .flag(flag_q),
  .pcnt(psc_cnt), .irq(irq_o)
);

// File: tb/prdt_timer_tb_top.sv
module prdt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ALL1 = 32'hFFFF_FFFF;

  logic        clk, rst_n, reg_wr, tick_a, tick_b, irq;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, rd;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit run_cmp = 0;

  prdt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rd), .tick_a_i(tick_a),
    .tick_b_i(tick_b), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [31:0] m_ctrl, m_load, m_cmp, m_cnt;
  bit m_flag, m_tk, m_exp, m_srct;
  int m_pc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_load = ALL1; m_cmp = 0; m_cnt = ALL1; m_flag = 0; m_pc = 0;
    end else if (reg_wr && reg_addr == 0) begin
      if (reg_wdata[16]) begin
        m_ctrl = 0; m_load = ALL1; m_cmp = 0; m_cnt = ALL1; m_flag = 0;
      end else m_ctrl = reg_wdata & 32'h03FE_FFFF;
      m_pc = 0;
    end else begin
      m_tk = 0; m_exp = 0;
      case (m_ctrl[25:24])
        2'd0: m_srct = 0;
        2'd3: m_srct = tick_b;
        default: m_srct = tick_a;
      endcase
      if (m_ctrl[0] && m_ctrl[25:24] != 0 && m_srct) begin
        if (m_pc == int'(m_ctrl[15:4])) begin m_pc = 0; m_tk = 1; end
        else m_pc++;
      end
      if (m_tk) begin
        if (m_cnt == 0) begin
          m_cnt = m_ctrl[3] ? m_load : ALL1; m_flag = 1; m_exp = 1;
        end else m_cnt--;
      end
      if (reg_wr && reg_addr == 1 && !m_exp) m_flag = 0;
      if (reg_wr && reg_addr == 2) begin
        if (m_ctrl[17]) m_cnt = reg_wdata;
        m_load = reg_wdata;
      end
      if (reg_wr && reg_addr == 3) m_cmp = reg_wdata;
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return {31'b0, m_flag};
      3'd2: return m_load;
      3'd3: return m_cmp;
      3'd4: return m_cnt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R2 ctrl";
      3'd1: return "R8 status";
      3'd2: return "R9 reload";
      3'd3: return "R12 compare";
      3'd4: return "R5 counter";
      default: return "R1 unmapped";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (run_cmp && rst_n) begin
    check("R7 irq", {31'b0, irq}, {31'b0, m_flag && m_ctrl[2]});
    check(tag_of(reg_addr), rd, m_read(reg_addr));
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=%0d expected<=40000", cyc);
      summary();
    end
  end

  task automatic drive(bit w, logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = w; reg_addr = a; reg_wdata = d;
  endtask
  task automatic wr(logic [2:0] a, logic [31:0] d);
    drive(1, a, d); drive(0, 3'd4, 0);
  endtask
  task automatic idle(int n);
    repeat (n) drive(0, 3'd4, 0);
  endtask
  task automatic chk_reg(logic [2:0] a, logic [31:0] exp, string tag);
    reg_addr = a; #1; check(tag, rd, exp);
  endtask

  function automatic logic [31:0] cw(bit en, bit ie, bit rld, bit imm, int div, int src);
    return {6'b0, 2'(src), 6'b0, imm, 1'b0, 12'(div), rld, ie, 1'b0, en};
  endfunction

  initial begin
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; tick_a = 0; tick_b = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    run_cmp = 1;
    // R10 hard reset values, R1 unmapped read
    chk_reg(0, 0, "R10 ctrl reset");
    chk_reg(1, 0, "R10 flag reset");
    chk_reg(2, ALL1, "R10 reload reset");
    chk_reg(3, 0, "R10 compare reset");
    chk_reg(4, ALL1, "R10 counter reset");
    chk_reg(5, 0, "R1 unmapped read");
    // R9 immediate load, R2 readback
    wr(0, cw(0, 0, 0, 1, 0, 0));
    wr(2, 5);
    chk_reg(4, 5, "R9 immediate load");
    tick_a = 1;
    wr(0, cw(1, 1, 1, 1, 0, 1) | 32'hFC3C_0002);
    chk_reg(0, cw(1, 1, 1, 1, 0, 1) | 32'h003C_0002, "R2 ctrl mask");
    idle(3);
    chk_reg(4, 2, "R5 decrement");
    idle(2);
    chk_reg(1, 0, "R5 no flag before expiry");
    idle(1);
    chk_reg(4, 5, "R6 reload from register");
    chk_reg(1, 1, "R5 flag on expiry");
    check("R7 irq high", {31'b0, irq}, 32'h1);
    wr(1, 0);
    chk_reg(1, 0, "R8 status write clears");
    check("R7 irq low", {31'b0, irq}, 32'h0);
    // R6 all-ones reload
    wr(0, cw(1, 1, 0, 1, 0, 1));
    wr(2, 2);
    idle(3);
    chk_reg(4, ALL1, "R6 reload all-ones");
    chk_reg(2, 2, "R9 reload kept");
    // R3 divide by 4 on source b
    tick_b = 1;
    wr(0, cw(1, 0, 1, 1, 3, 3));
    wr(2, 100);
    idle(8);
    chk_reg(4, 98, "R3 divided rate");
    // R11 control rewrite restarts divider
    wr(0, cw(0, 0, 1, 1, 3, 1));
    wr(2, 50);
    wr(0, cw(1, 0, 1, 1, 3, 1));
    idle(2);
    wr(0, cw(1, 0, 1, 1, 3, 1));
    idle(3);
    chk_reg(4, 50, "R11 divider restarted");
    idle(1);
    chk_reg(4, 49, "R11 tick after full period");
    // R4 hold with no source / disabled
    wr(0, cw(1, 0, 1, 1, 0, 0));
    wr(2, 9);
    idle(10);
    chk_reg(4, 9, "R4 source off holds");
    wr(0, cw(0, 0, 1, 1, 0, 1));
    idle(10);
    chk_reg(4, 9, "R4 disabled holds");
    // R1 counter offset read only, R12 compare
    wr(4, 32'h7);
    chk_reg(4, 9, "R1 counter write ignored");
    wr(6, 32'h55);
    chk_reg(6, 0, "R1 unmapped write ignored");
    wr(3, 32'hDEAD_1234);
    chk_reg(3, 32'hDEAD_1234, "R12 compare stored");
    chk_reg(4, 9, "R12 compare no effect");
    // R10 soft reset
    wr(0, cw(1, 1, 1, 1, 2, 1) | 32'h0001_0000);
    chk_reg(0, 0, "R10 soft reset ctrl");
    chk_reg(2, ALL1, "R10 soft reset reload");
    chk_reg(3, 0, "R10 soft reset compare");
    chk_reg(4, ALL1, "R10 soft reset counter");
    // random phase, model compared every cycle (R3 R5 R6 R8 R9 R11)
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [31:0] d;
      r = $urandom % 100;
      tick_a = $urandom % 2; tick_b = $urandom % 3 == 0;
      if (r < 8) begin
        d = cw($urandom % 8 != 0, $urandom % 2, $urandom % 2, $urandom % 2,
               $urandom % 3, $urandom % 4);
        d[31:26] = 6'($urandom); d[21:18] = 4'($urandom); d[1] = 1'($urandom);
        d[16] = ($urandom % 40 == 0);
        drive(1, 0, d);
      end else if (r < 20) drive(1, 1, $urandom);
      else if (r < 28) drive(1, 2, $urandom % 12);
      else if (r < 30) drive(1, 3'($urandom % 8), $urandom);
      else drive(0, 3'($urandom % 8), 0);
    end
    // R10 hard reset while running
    drive(0, 4, 0);
    run_cmp = 0;
    rst_n = 0;
    #1;
    chk_reg(4, ALL1, "R10 hard reset counter");
    chk_reg(0, 0, "R10 hard reset ctrl");
    summary();
  end
endmodule